// File: doc/BRIEF.md
# DDR Command Bus Issuer with One- or Two-Cycle Command Timing

This block sits between a memory controller's scheduler and the command/address pins of a DDR SDRAM channel. The scheduler hands over one command at a time on a valid/ready handshake. Each command carries a 3-bit operation code, a row/column address, a bank number and a rank number. The block puts the command on the bus, strobes the chip select of the chosen rank and then returns the command lines to a no-operation state.

A mode input selects the command timing. In single-cycle timing a new command can go out on every clock. In double-cycle timing the address, bank and RAS#/CAS#/WE# lines are held for two clocks. This gives heavily loaded buses a full extra cycle of setup. Chip select and CKE keep single-cycle timing in both modes. In double-cycle mode the chip select is pulsed only in the second cycle of the window, so peak command throughput halves.

All bus outputs are launched from falling-edge registers, so they are centred on the rising edge at which the DRAM samples them.

Top module: `ddr_cmd_issuer`

## Requirements
- R1: While reset is high and after it is released, every chip select, RAS#, CAS# and WE# is driven high, CKE is driven low and `cmd_ready` is high. The active mode is single-cycle.
- R2: In single-cycle mode, a command accepted at rising edge k appears on the bus from the falling edge that follows it, so the DRAM samples it at edge k+1. The bus then carries `cmd_addr`, `cmd_bank` and RAS# = `cmd_op[2]`, CAS# = `cmd_op[1]`, WE# = `cmd_op[0]`.
- R3: In single-cycle mode `cmd_ready` stays high, and a stream of valid commands produces one chip-select strobe per clock.
- R4: In double-cycle mode, the address, bank, RAS#, CAS# and WE# lines stay unchanged over the two consecutive DRAM sampling edges of each command.
- R5: In double-cycle mode, chip select is high at the first sampling edge of a command's window and low at the second edge only.
- R6: After a double-cycle command is accepted, `cmd_ready` is low for exactly one cycle, so back-to-back double-cycle commands are two clocks apart.
- R7: With no command issued, RAS#, CAS# and WE# are high and all chip selects are high, while the address and bank lines keep their last values.
- R8: `mode_2t` is copied into the active mode at each rising edge where no double-cycle command is in its first cycle. A command uses the active mode held at its acceptance edge, so a change made during an in-flight command does not affect the next command accepted.
- R9: Only `dram_cs_n[cmd_rank]` goes low for a command; every other rank stays deselected.
- R10: `dram_cke` follows `cke_req` through one falling-edge register in both modes, and is low while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Scheduler offers a command |
| cmd_ready | output | 1 | Issuer accepts a command at this edge |
| cmd_op | input | 3 | Operation code, bit 2 = RAS#, bit 1 = CAS#, bit 0 = WE# |
| cmd_addr | input | ADDR_W (15) | Row or column address |
| cmd_bank | input | BANK_W (2) | Bank number |
| cmd_rank | input | RANK_W (1) | Target rank |
| mode_2t | input | 1 | 1 selects double-cycle command timing |
| cke_req | input | 1 | Requested clock-enable level |
| dram_addr | output | ADDR_W (15) | Multiplexed DRAM address |
| dram_ba | output | BANK_W (2) | DRAM bank address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_cs_n | output | RANKS (2) | Per-rank chip selects, active low |
| dram_cke | output | 1 | Clock enable |

## Verification
A command accepted at rising edge k is on the bus from the falling edge that follows it. The bench therefore reads every output three quarters of a period after each rising edge, which is after that launch and before the next edge. That reading is what the DRAM sees at edge k+1. In double-cycle mode, the second sampling edge of the command window falls one read later. `cmd_ready` changes at the rising edge itself, so each read reflects the acceptance just made. CKE shares the same one-falling-edge latency, so its value at each read is the request driven in the previous cycle. The reference model advances once per rising edge, using the inputs the bench held over that edge, and is compared at exactly this read point.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  // Operation code is the raw {RAS#, CAS#, WE#} pattern.
  typedef logic [2:0] cmd_code_t;

  localparam cmd_code_t CMD_IDLE = 3'b111;

  typedef enum logic {
    TIMING_1T = 1'b0,
    TIMING_2T = 1'b1
  } cmd_timing_e;

endpackage

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BANK_W = 2,
  parameter int RANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  cmd_code_t         in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [RANK_W-1:0] in_rank,
  input  logic              in_mode,
  output logic [ADDR_W-1:0] q_addr,
  output logic [BANK_W-1:0] q_bank,
  output cmd_code_t         q_op,
  output logic [RANK_W-1:0] q_rank,
  output logic              q_fire
);

  cmd_timing_e mode_q;
  logic        hold_q;   // high during the first cycle of a 2T window
  logic        accept;

  assign in_ready = !hold_q;
  assign accept   = in_valid && !hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TIMING_1T;
      hold_q <= 1'b0;
      q_addr <= '0;
      q_bank <= '0;
      q_op   <= CMD_IDLE;
      q_rank <= '0;
      q_fire <= 1'b0;
    end else if (hold_q) begin
      // Second cycle of the window: lines held, strobe now.
      hold_q <= 1'b0;
      q_fire <= 1'b1;
    end else begin
      mode_q <= cmd_timing_e'(in_mode);
      if (accept) begin
        q_addr <= in_addr;
        q_bank <= in_bank;
        q_op   <= in_op;
        q_rank <= in_rank;
        hold_q <= (mode_q == TIMING_2T);
        q_fire <= (mode_q == TIMING_1T);
      end else begin
        q_op   <= CMD_IDLE;
        q_fire <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ddr_cmd_launch.sv
module ddr_cmd_launch
  import ddr_cmd_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BANK_W = 2,
  parameter int RANKS  = 2,
  parameter int RANK_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [BANK_W-1:0] q_bank,
  input  cmd_code_t         q_op,
  input  logic [RANK_W-1:0] q_rank,
  input  logic              q_fire,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BANK_W-1:0] bus_ba,
  output logic              bus_ras_n,
  output logic              bus_cas_n,
  output logic              bus_we_n,
  output logic [RANKS-1:0]  bus_cs_n
);

  logic [RANKS-1:0] rank_hit;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank_dec
    assign rank_hit[r] = q_fire && (q_rank == RANK_W'(r));
  end

  // Falling-edge launch centres the lines on the DRAM's rising sample edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_ba    <= '0;
      bus_ras_n <= 1'b1;
      bus_cas_n <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_cs_n  <= '1;
    end else begin
      bus_addr  <= q_addr;
      bus_ba    <= q_bank;
      bus_ras_n <= q_op[2];
      bus_cas_n <= q_op[1];
      bus_we_n  <= q_op[0];
      bus_cs_n  <= ~rank_hit;
    end
  end

endmodule

// File: rtl/ddr_cke_stage.sv
module ddr_cke_stage (
  input  logic clk,
  input  logic rst,
  input  logic cke_in,
  output logic cke_out
);

  always_ff @(negedge clk) begin
    if (rst) cke_out <= 1'b0;
    else     cke_out <= cke_in;
  end

endmodule

// File: rtl/ddr_cmd_issuer.sv
module ddr_cmd_issuer
  import ddr_cmd_pkg::*;
#(
  parameter  int ADDR_W = 15,
  parameter  int BANK_W = 2,
  parameter  int RANKS  = 2,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [RANK_W-1:0] cmd_rank,
  input  logic              mode_2t,
  input  logic              cke_req,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [BANK_W-1:0] dram_ba,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [RANKS-1:0]  dram_cs_n,
  output logic              dram_cke
);

  logic [ADDR_W-1:0] s_addr;
  logic [BANK_W-1:0] s_bank;
  cmd_code_t         s_op;
  logic [RANK_W-1:0] s_rank;
  logic              s_fire;

  ddr_cmd_seq #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .RANK_W (RANK_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (cmd_valid),
    .in_ready (cmd_ready),
    .in_op    (cmd_op),
    .in_addr  (cmd_addr),
    .in_bank  (cmd_bank),
    .in_rank  (cmd_rank),
    .in_mode  (mode_2t),
    .q_addr   (s_addr),
    .q_bank   (s_bank),
    .q_op     (s_op),
    .q_rank   (s_rank),
    .q_fire   (s_fire)
  );

  ddr_cmd_launch #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .RANKS  (RANKS),
    .RANK_W (RANK_W)
  ) u_launch (
    .clk       (clk),
    .rst       (rst),
    .q_addr    (s_addr),
    .q_bank    (s_bank),
    .q_op      (s_op),
    .q_rank    (s_rank),
    .q_fire    (s_fire),
    .bus_addr  (dram_addr),
    .bus_ba    (dram_ba),
    .bus_ras_n (dram_ras_n),
    .bus_cas_n (dram_cas_n),
    .bus_we_n  (dram_we_n),
    .bus_cs_n  (dram_cs_n)
  );

  ddr_cke_stage u_cke (
    .clk     (clk),
    .rst     (rst),
    .cke_in  (cke_req),
    .cke_out (dram_cke)
  );

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker #(
  parameter int ADDR_W = 15,
  parameter int BANK_W = 2,
  parameter int RANKS  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] dram_addr,
  input logic [BANK_W-1:0] dram_ba,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic [RANKS-1:0]  dram_cs_n,
  input logic              dram_cke
);

  // R9: at most one rank selected at any sampling edge.
  a_r9_single_rank: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dram_cs_n));

  // R4: lines unchanged across the two edges of a 2T window.
  a_r4_lines_held: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> $stable({dram_addr, dram_ba, dram_ras_n, dram_cas_n, dram_we_n}));

  // R5: no strobe in the first cycle of a 2T window.
  a_r5_no_early_cs: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |-> (&dram_cs_n));

  // R5: strobe in the second cycle of a 2T window.
  a_r5_cs_second: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> !(&dram_cs_n));

  // R6: ready is low for one cycle only.
  a_r6_one_stall: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> cmd_ready);

  // R10: clock enable driven low under reset.
  a_r10_cke_reset: assert property (@(posedge clk)
    rst |=> !dram_cke);

endmodule

bind ddr_cmd_issuer ddr_cmd_checker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .RANKS  (RANKS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_ready  (cmd_ready),
  .dram_addr  (dram_addr),
  .dram_ba    (dram_ba),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_cs_n  (dram_cs_n),
  .dram_cke   (dram_cke)
);

// File: tb/test_ddr_cmd_issuer.sv
module test_ddr_cmd_issuer;

  localparam int AW = 15;
  localparam int BW = 2;
  localparam int NR = 2;
  localparam int RW = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = 3'b111;
  logic [AW-1:0] cmd_addr = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic [RW-1:0] cmd_rank = '0;
  logic          mode_2t = 1'b0;
  logic          cke_req = 1'b0;
  logic [AW-1:0] dram_addr;
  logic [BW-1:0] dram_ba;
  logic          dram_ras_n, dram_cas_n, dram_we_n;
  logic [NR-1:0] dram_cs_n;
  logic          dram_cke;

  ddr_cmd_issuer #(.ADDR_W(AW), .BANK_W(BW), .RANKS(NR)) i_ddr_cmd_issuer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bank(cmd_bank), .cmd_rank(cmd_rank),
    .mode_2t(mode_2t), .cke_req(cke_req), .dram_addr(dram_addr), .dram_ba(dram_ba),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_cs_n(dram_cs_n), .dram_cke(dram_cke)
  );

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  bit done = 1'b0;

  // Reference model, advanced once per rising edge.
  bit          m_mode, m_hold, m_fire, m_two, m_idle, m_cke;
  logic [2:0]  m_op;
  logic [AW-1:0] m_addr;
  logic [BW-1:0] m_bank;
  logic [RW-1:0] m_rank;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] exp_cs();
    logic [NR-1:0] v = '1;
    if (m_fire) v[m_rank] = 1'b0;
    return v;
  endfunction

  task automatic model_edge();
    m_cke = rst ? 1'b0 : cke_req;
    if (rst) begin
      m_mode = 0; m_hold = 0; m_fire = 0; m_two = 0; m_idle = 1;
      m_op = 3'b111; m_addr = '0; m_bank = '0; m_rank = '0;
    end else if (m_hold) begin
      m_hold = 0; m_fire = 1;
    end else begin
      if (cmd_valid) begin
        m_op = cmd_op; m_addr = cmd_addr; m_bank = cmd_bank; m_rank = cmd_rank;
        m_two = m_mode; m_hold = m_mode; m_fire = !m_mode; m_idle = 0;
      end else begin
        m_op = 3'b111; m_fire = 0; m_idle = 1;
      end
      m_mode = mode_2t;
    end
  endtask

  task automatic compare();
    logic [19:0] act_bus, exp_bus;
    act_bus = {dram_addr, dram_ba, dram_ras_n, dram_cas_n, dram_we_n};
    exp_bus = {m_addr, m_bank, m_op};
    if (m_idle)     chk(act_bus == exp_bus, "R7 idle bus", 32'(act_bus), 32'(exp_bus));
    else if (m_two) chk(act_bus == exp_bus, "R4 2T bus", 32'(act_bus), 32'(exp_bus));
    else            chk(act_bus == exp_bus, "R2 1T bus", 32'(act_bus), 32'(exp_bus));
    chk(dram_cs_n == exp_cs(), "R9 chip select", 32'(dram_cs_n), 32'(exp_cs()));
    if (m_hold) chk(&dram_cs_n, "R5 no strobe in first cycle", 32'(dram_cs_n), 32'(3));
    chk(cmd_ready == !m_hold, "R6 ready", 32'(cmd_ready), 32'(!m_hold));
    chk(dram_cke == m_cke, "R10 cke", 32'(dram_cke), 32'(m_cke));
    if (!(&dram_cs_n)) strobes++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #15;
    compare();
  endtask

  task automatic drive(input bit v, input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [BW-1:0] b, input logic [RW-1:0] r);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_bank = b; cmd_rank = r;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));

    // R1: reset state
    for (int i = 0; i < 3; i++) step();
    chk(&dram_cs_n, "R1 cs high in reset", 32'(dram_cs_n), 32'(3));
    chk({dram_ras_n, dram_cas_n, dram_we_n} == 3'b111, "R1 NOP in reset",
        32'({dram_ras_n, dram_cas_n, dram_we_n}), 32'(7));
    chk(dram_cke == 1'b0, "R1 cke low in reset", 32'(dram_cke), 32'(0));
    rst = 1'b0; cke_req = 1'b1;
    step();
    chk(cmd_ready == 1'b1, "R1 ready after reset", 32'(cmd_ready), 32'(1));

    // R3: 1T throughput, one strobe per clock
    drive(1, 3'b011, 15'h1234, 2'd1, 1'd0);
    step();
    n = strobes;
    for (int i = 0; i < 8; i++) begin
      drive(1, 3'(i), 15'(i * 97), 2'(i), 1'(i));
      step();
    end
    chk(strobes - n == 8, "R3 1T throughput", 32'(strobes - n), 32'(8));
    drive(0, 3'b101, 15'h0, 2'd0, 1'd0);
    step();

    // R6: 2T throughput, one strobe per two clocks
    mode_2t = 1'b1;
    step(); step();
    n = strobes;
    for (int i = 0; i < 8; i++) begin
      drive(1, 3'(7 - i), 15'(i * 211), 2'(i + 1), 1'(i >> 1));
      step();
    end
    chk(strobes - n == 4, "R6 2T throughput", 32'(strobes - n), 32'(4));
    drive(0, 3'b000, 15'h0, 2'd0, 1'd0);
    step(); step();

    // R8: mode flip during an in-flight 2T command is deferred
    drive(1, 3'b100, 15'h7ABC, 2'd2, 1'd1);
    step();                        // accepted as 2T, first cycle
    mode_2t = 1'b0;
    drive(1, 3'b101, 15'h0F0F, 2'd3, 1'd0);
    step();                        // second cycle, not accepted
    step();                        // accepted with the held 2T mode
    chk(cmd_ready == 1'b0, "R8 next command still 2T", 32'(cmd_ready), 32'(0));
    drive(0, 3'b000, 15'h0, 2'd0, 1'd0);
    step();
    drive(1, 3'b010, 15'h0055, 2'd0, 1'd1);
    step();
    chk(cmd_ready == 1'b1, "R8 new mode applied after completion", 32'(cmd_ready), 32'(1));
    drive(0, 3'b000, 15'h0, 2'd0, 1'd0);
    step();

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 4) != 0, 3'($urandom), 15'($urandom), 2'($urandom),
            1'($urandom % NR));
      if (($urandom % 16) == 0) mode_2t = ~mode_2t;
      if (($urandom % 8) == 0)  cke_req = ~cke_req;
      step();
    end

    // R10: reset mid-run forces cke low
    rst = 1'b1;
    step(); step();
    chk(dram_cke == 1'b0, "R10 cke low in reset", 32'(dram_cke), 32'(0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule